// File: doc/BRIEF.md
# Serial Port Receive Queue and Interrupt Status

This block sits behind the shift engine of a synchronous serial port and owns everything the receive side reports to software. Each completed frame from the shift engine is offered to an eight-entry first-in first-out queue. Software drains the queue through a read strobe. The oldest word is always visible on the read-data output before it is popped.

Two fault conditions are tracked. The first is an overflow: a frame that completes while the queue is full and is not popped in the same cycle. The second is stale data: words that sit in the queue while the port stays idle for 32 bit periods. These two, a fill-level request and a transmit request supplied from outside, make four interrupt sources. Each source is exported raw and masked, and the masked sources are ORed into one combined line.

The overflow is judged only at frame completion. A read taken while the overflowing frame is still shifting frees a slot, so that frame is stored normally. Once an overflow is flagged, every later frame is dropped until software writes the clear strobe.

Top module: `sport_rx_status`

## Requirements
- R1: The queue stores up to 8 frames and returns them on `rd_data` in arrival order; `rx_not_empty` is 1 whenever at least one word is held.
- R2: A frame that completes while the queue holds 8 words, with no pop in the same cycle, is dropped and sets the overrun source (`irq_raw[3]`) one cycle after the completion strobe.
- R3: A pop taken before or in the same cycle as the completion of the ninth frame lets that frame be stored, and no overrun is flagged.
- R4: While the overrun source is set, every completed frame is dropped and the queue contents are unchanged.
- R5: A clear strobe `ovr_clr` drops the overrun source on the next cycle; stored words stay in the queue.
- R6: The timeout source (`irq_raw[2]`) rises after 32 `bit_tick` pulses counted while the queue is non-empty with no pop, transfer start or overrun clear. It stays 0 after 31 such pulses and stays 0 while the queue is empty.
- R7: A transfer start drops the timeout source on the next cycle and restarts the idle count. A transfer start with a full queue, followed by a frame completion, yields an overrun.
- R8: A pop or an overrun clear restarts the idle count, so the timeout source needs another 32 idle bit periods before it rises again.
- R9: The receive-level source (`irq_raw[1]`) is 1 when the queue holds 4 or more words. The transmit source (`irq_raw[0]`) follows `tx_req_in`.
- R10: `irq_masked` is `irq_raw & irq_mask` bit by bit; bit 0 is transmit, bit 1 is receive level, bit 2 is timeout and bit 3 is overrun. `irq_any` is the OR of `irq_masked`.
- R11: A pop strobe while the queue is empty is ignored: the queue stays empty and the next stored frame is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: the shift engine finished a frame |
| frame_data | input | 8 | Received frame, valid with `frame_done` |
| xfer_start | input | 1 | One-cycle strobe: a new transfer begins |
| bit_tick | input | 1 | One pulse per serial bit period |
| rd_en | input | 1 | Pop the oldest word |
| ovr_clr | input | 1 | Clear the overrun condition |
| tx_req_in | input | 1 | Raw transmit interrupt request |
| irq_mask | input | 4 | Per-source enable, 1 = enabled |
| rd_data | output | 8 | Oldest stored word |
| rx_not_empty | output | 1 | Queue holds at least one word |
| irq_raw | output | 4 | Unmasked interrupt sources |
| irq_masked | output | 4 | Masked interrupt sources |
| irq_any | output | 1 | OR of the masked sources |

## Verification
A wrong fill level shows up within one cycle as a wrong `rx_not_empty`, a wrong receive-level bit or a misplaced overrun. It also surfaces later as words that are missing, duplicated or out of order when the queue is drained. A wrong idle count is only visible at the 31st and 32nd counted bit periods, so the bench samples the timeout source on both sides of that edge. It does so after each event that restarts the count. A mishandled overrun flag shows as frames that survive or vanish, and this is exposed by reading back every stored word after a clear.

// File: rtl/sport_rx_pkg.sv
package sport_rx_pkg;
  localparam int NUM_IRQ = 4;
  localparam int IRQ_TX  = 0;
  localparam int IRQ_RX  = 1;
  localparam int IRQ_TO  = 2;
  localparam int IRQ_OVR = 3;
  typedef logic [NUM_IRQ-1:0] irq_vec_t;
endpackage

// File: rtl/sport_rst_sync.sv
module sport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sport_rx_queue.sv
module sport_rx_queue #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic          ovr_clr,
  output logic [DW-1:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic          not_empty,
  output logic          ovr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] level_q, level_d;
  logic          ovr_q, ovr_d;
  logic          full, do_rd, ovr_eff, wr_ok, ovr_hit;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full    = (level_q == CW'(DEPTH));
    do_rd   = rd_req && (level_q != '0);
    ovr_eff = ovr_q && !ovr_clr;
    wr_ok   = wr_req && !ovr_eff && (!full || do_rd);
    ovr_hit = wr_req && !ovr_eff && full && !do_rd;
    ovr_d   = ovr_eff || ovr_hit;
    wp_d    = wr_ok ? bump(wp_q) : wp_q;
    rp_d    = do_rd ? bump(rp_q) : rp_q;
    level_d = level_q + CW'(wr_ok) - CW'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      level_q <= level_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  assign rd_data   = mem[rp_q];
  assign level     = level_q;
  assign not_empty = (level_q != '0);
  assign ovr       = ovr_q;

  // R1: fill level never passes the depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH));
  // R2: overrun only rises from a completion that met a full queue
  a_r2_ovr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(wr_req && full && !rd_req));
  // R4: frames completing under an uncleared overrun are not stored
  a_r4_drop_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr && wr_req && !rd_req) |=> (level_q == $past(level_q)));
  // R5: clear without a colliding completion drops the flag
  a_r5_clear_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !wr_req) |=> !ovr_q);
endmodule

// File: rtl/sport_idle_timer.sv
module sport_idle_timer #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic armed,
  output logic expired
);
  localparam int TW = $clog2(LIMIT+1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          at_limit, cnt_en;

  always_comb begin
    at_limit = (cnt_q == TW'(LIMIT));
    cnt_en   = tick && !at_limit;
    if (restart || !armed) cnt_d = '0;
    else if (cnt_en)       cnt_d = cnt_q + TW'(1);
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = at_limit && armed;

  // R7: a restart removes the timeout on the next cycle
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);
  // R6: the timeout only rises on a counted bit period
  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(tick));
endmodule

// File: rtl/sport_irq_merge.sv
module sport_irq_merge
  import sport_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t raw,
  input  irq_vec_t mask,
  output irq_vec_t masked,
  output logic     any
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign masked[i] = raw[i] && mask[i];
  end

  assign any = |masked;

  // R10: the combined line needs an enabled, active source
  a_r10_any_source: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((raw & mask) != '0));
endmodule

// File: rtl/sport_rx_status.sv
module sport_rx_status
  import sport_rx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DW       = 8,
  parameter int IDLE_LIM = 32,
  parameter int RX_LEVEL = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  logic [DW-1:0]       frame_data,
  input  logic                xfer_start,
  input  logic                bit_tick,
  input  logic                rd_en,
  input  logic                ovr_clr,
  input  logic                tx_req_in,
  input  logic [NUM_IRQ-1:0]  irq_mask,
  output logic [DW-1:0]       rd_data,
  output logic                rx_not_empty,
  output logic [NUM_IRQ-1:0]  irq_raw,
  output logic [NUM_IRQ-1:0]  irq_masked,
  output logic                irq_any
);
  localparam int CW = $clog2(DEPTH+1);

  logic          rst_n_s;
  logic [CW-1:0] level;
  logic          not_empty, ovr, timeout, idle_restart;
  irq_vec_t      raw_vec;

  sport_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sport_rx_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_req    (frame_done),
    .wr_data   (frame_data),
    .rd_req    (rd_en),
    .ovr_clr   (ovr_clr),
    .rd_data   (rd_data),
    .level     (level),
    .not_empty (not_empty),
    .ovr       (ovr)
  );

  assign idle_restart = xfer_start || rd_en || ovr_clr;

  sport_idle_timer #(.LIMIT(IDLE_LIM)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (bit_tick),
    .restart (idle_restart),
    .armed   (not_empty),
    .expired (timeout)
  );

  always_comb begin
    raw_vec          = '0;
    raw_vec[IRQ_TX]  = tx_req_in;
    raw_vec[IRQ_RX]  = (level >= CW'(RX_LEVEL));
    raw_vec[IRQ_TO]  = timeout;
    raw_vec[IRQ_OVR] = ovr;
  end

  sport_irq_merge u_merge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .raw    (raw_vec),
    .mask   (irq_mask),
    .masked (irq_masked),
    .any    (irq_any)
  );

  assign irq_raw      = raw_vec;
  assign rx_not_empty = not_empty;

  // R6: no timeout on an empty queue
  a_r6_needs_data: assert property (@(posedge clk) disable iff (!rst_n_s)
    timeout |-> not_empty);
endmodule

// File: tb/sim_sport_rx_status.sv
module sim_sport_rx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_done = 1'b0;
  logic [7:0] frame_data = '0;
  logic       xfer_start = 1'b0;
  logic       bit_tick = 1'b0;
  logic       rd_en = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       tx_req_in = 1'b0;
  logic [3:0] irq_mask = '0;
  logic [7:0] rd_data;
  logic       rx_not_empty;
  logic [3:0] irq_raw, irq_masked;
  logic       irq_any;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sport_rx_status u0 (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .xfer_start(xfer_start), .bit_tick(bit_tick), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .tx_req_in(tx_req_in), .irq_mask(irq_mask), .rd_data(rd_data),
    .rx_not_empty(rx_not_empty), .irq_raw(irq_raw), .irq_masked(irq_masked),
    .irq_any(irq_any)
  );

  // op[18:17]: 0 frame, 1 pop (data = expected head), 2 transfer start
  // data[16:9], expected not_empty[8], receive level[7], overrun[6]
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'h10, 3'b100, 6'd0},
    {2'd0, 8'h11, 3'b100, 6'd0},
    {2'd0, 8'h12, 3'b100, 6'd0},
    {2'd0, 8'h13, 3'b110, 6'd0},
    {2'd0, 8'h14, 3'b110, 6'd0},
    {2'd0, 8'h15, 3'b110, 6'd0},
    {2'd0, 8'h16, 3'b110, 6'd0},
    {2'd0, 8'h17, 3'b110, 6'd0},
    {2'd0, 8'h18, 3'b111, 6'd0},
    {2'd0, 8'h19, 3'b111, 6'd0},
    {2'd1, 8'h10, 3'b111, 6'd0},
    {2'd2, 8'h00, 3'b111, 6'd0},
    {2'd1, 8'h11, 3'b111, 6'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); frame_done = 1'b1; frame_data = d;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic pop(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic start_xfer();
    @(negedge clk); xfer_start = 1'b1;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic clear_ovr();
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset empty", rx_not_empty, 0);
    chk("R10 reset raw", irq_raw, 0);
    chk("R10 reset any", irq_any, 0);

    // table: fill, overflow, drop under overrun, pops
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][18:17])
        2'd0: put(VEC[v][16:9]);
        2'd1: pop("R1 table head", VEC[v][16:9]);
        default: start_xfer();
      endcase
      chk("R1 table not_empty", rx_not_empty, VEC[v][8]);
      chk("R9 table level", irq_raw[1], VEC[v][7]);
      chk("R2 table overrun", irq_raw[3], VEC[v][6]);
    end

    // R5 clear keeps data; R4 dropped frames absent
    clear_ovr();
    chk("R5 overrun cleared", irq_raw[3], 0);
    chk("R5 data kept", rx_not_empty, 1);
    for (int k = 2; k < 8; k++) pop("R4 drain order", 8'h10 + 8'(k));
    chk("R4 dropped frames absent", rx_not_empty, 0);

    // R11 pop on empty ignored
    pop("R11 empty pop", rd_data);
    chk("R11 still empty", rx_not_empty, 0);
    put(8'h5A);
    pop("R11 next word", 8'h5A);
    chk("R11 empty after", rx_not_empty, 0);

    // R3 rescue: pop during the ninth frame, then pop in the completion cycle
    for (int k = 0; k < 8; k++) put(8'h20 + 8'(k));
    start_xfer();
    pop("R3 head before rescue", 8'h20);
    put(8'h28);
    chk("R3 no overrun after rescue", irq_raw[3], 0);
    @(negedge clk);
    chk("R3 head before same-cycle pop", rd_data, 8'h21);
    frame_done = 1'b1; frame_data = 8'h29; rd_en = 1'b1;
    @(negedge clk); frame_done = 1'b0; rd_en = 1'b0;
    chk("R3 no overrun same-cycle", irq_raw[3], 0);
    for (int k = 2; k < 10; k++) pop("R3 rescued order", 8'h20 + 8'(k));
    chk("R3 drained", rx_not_empty, 0);

    // R6 timeout threshold and masking
    put(8'h30);
    ticks(31);
    chk("R6 no timeout at 31", irq_raw[2], 0);
    ticks(1);
    chk("R6 timeout at 32", irq_raw[2], 1);
    irq_mask = 4'b0100;
    #1 chk("R10 timeout enabled any", irq_any, 1);
    chk("R10 masked bit2", irq_masked, 4'b0100);
    irq_mask = 4'b1011;
    #1 chk("R10 timeout masked any", irq_any, 0);
    irq_mask = 4'b0000;
    start_xfer();
    chk("R7 start clears timeout", irq_raw[2], 0);
    ticks(31);
    chk("R7 recount 31", irq_raw[2], 0);
    ticks(1);
    chk("R7 recount 32", irq_raw[2], 1);
    pop("R8 pop head", 8'h30);
    chk("R8 pop clears timeout", irq_raw[2], 0);
    ticks(40);
    chk("R6 empty no timeout", irq_raw[2], 0);

    // R8 rearm after overrun clear; R7 start with full queue then overrun
    for (int k = 0; k < 9; k++) put(8'h40 + 8'(k));
    chk("R2 overrun set", irq_raw[3], 1);
    ticks(33);
    clear_ovr();
    chk("R8 clear restarts idle", irq_raw[2], 0);
    chk("R5 cleared again", irq_raw[3], 0);
    ticks(31);
    chk("R8 rearm 31", irq_raw[2], 0);
    ticks(1);
    chk("R8 rearm 32", irq_raw[2], 1);
    start_xfer();
    chk("R7 full start clears timeout", irq_raw[2], 0);
    put(8'h49);
    chk("R7 full start then overrun", irq_raw[3], 1);

    // R9 / R10 transmit source
    tx_req_in = 1'b1;
    irq_mask = 4'b0001;
    #1 chk("R9 tx raw", irq_raw[0], 1);
    chk("R10 tx any", irq_any, 1);
    irq_mask = 4'b1000;
    #1 chk("R10 ovr masked", irq_masked, 4'b1000);
    irq_mask = 4'b0000;
    #1 chk("R10 all masked", irq_any, 0);

    finish_run();
  end
endmodule